// File: doc/BRIEF.md
# Physical Register Free List

This block keeps track of which physical registers a register-renaming pipeline may hand out next. The physical index space is split in two: the low part holds integer registers and the part above it holds floating-point registers. Each half has its own pool. A pool is a first-in first-out queue of free indices, so registers come back into use in the order they were freed. Rename logic asks each pool for a register through its own allocation port. The registered answer, an index with a one-cycle valid strobe, arrives on the following clock.

Registers come back through three release ports. A generic port routes an index to the correct pool by its value. It silently drops indices beyond the last physical register. It also drops the two hard-wired zero registers (one per half), because those must never be renamed. Two dedicated ports, one per pool, push their index without the zero filter. A per-register occupancy bitmap rejects any release of a register that is already free. That case, a dedicated-port index outside its pool's half, and a request to an empty pool all raise a sticky error flag. Each pool reports a not-empty flag and its current free count.

Top module: `prf_free_list`

## Requirements
- R1: After reset the integer pool holds indices NUM_LOG_INT..NUM_PHYS_INT-1 and the floating-point pool holds NUM_PHYS_INT+NUM_LOG_FP..NUM_PHYS_INT+NUM_PHYS_FP-1. Both counts equal their sizes, both not-empty flags are 1, the error flag is 0 and both valid strobes are 0.
- R2: Each pool hands out indices in the order they entered it; the reset contents enter in ascending order. Integer indices are below NUM_PHYS_INT. Floating-point indices lie from NUM_PHYS_INT to NUM_PHYS_INT+NUM_PHYS_FP-1.
- R3: A request to a pool whose count is nonzero gives valid=1 on the next cycle with the head index. The count then drops by one, unless a release into that pool is accepted in the same cycle.
- R4: A request to a pool whose count is zero gives valid=0 with index 0 on the next cycle and sets the error flag. Whenever valid is 0 the index output is 0.
- R5: The generic release port sends an index below NUM_PHYS_INT to the integer pool and an index from NUM_PHYS_INT to NUM_PHYS_INT+NUM_PHYS_FP-1 to the floating-point pool. It drops any larger index without changing any output.
- R6: On the generic port, index ZERO_REG and index NUM_PHYS_INT+ZERO_REG are dropped without effect and without error.
- R7: The dedicated release ports push their index into their pool even when it is a zero register.
- R8: A dedicated-port index outside that pool's half of the index space is dropped and sets the error flag.
- R9: A release of a register that is currently free, including the same register offered twice in one cycle, is dropped and sets the error flag.
- R10: An allocation and an accepted release on the same pool in one cycle both take effect. The count stays the same and the released index queues behind the existing entries.
- R11: When the dedicated port and the generic port both push into the same pool in one cycle, the dedicated port's index is queued ahead of the generic port's.
- R12: The error flag stays set until reset.
- R13: Each free count equals the number of entries in its pool, and each not-empty flag is 1 exactly when that count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_alloc_req | input | 1 | Request one integer register |
| fp_alloc_req | input | 1 | Request one floating-point register |
| int_alloc_valid | output | 1 | Integer allocation result valid (one cycle) |
| int_alloc_idx | output | IDX_W | Allocated integer physical index |
| fp_alloc_valid | output | 1 | Floating-point allocation result valid (one cycle) |
| fp_alloc_idx | output | IDX_W | Allocated floating-point physical index |
| gen_rel_vld | input | 1 | Generic release strobe |
| gen_rel_idx | input | IDX_W | Generic release index, routed by range |
| int_rel_vld | input | 1 | Dedicated integer release strobe |
| int_rel_idx | input | IDX_W | Dedicated integer release index |
| fp_rel_vld | input | 1 | Dedicated floating-point release strobe |
| fp_rel_idx | input | IDX_W | Dedicated floating-point release index |
| int_nonempty | output | 1 | Integer pool has at least one entry |
| int_free_cnt | output | CNT_W | Integer pool entry count |
| fp_nonempty | output | 1 | Floating-point pool has at least one entry |
| fp_free_cnt | output | CNT_W | Floating-point pool entry count |
| pool_err | output | 1 | Sticky error flag |

## Verification
Every result of this block is due one rising edge after its stimulus. The allocation strobe and index, both free counts, both not-empty flags and the error flag all change on the edge that samples the request or release. The bench therefore drives each cycle's inputs on a falling edge and compares all outputs on the next falling edge, against a queue-and-bitmap model updated in the same step. Allocation uses the pool contents from before that edge, so a release accepted in the same cycle can never satisfy a request on an empty pool.

// File: rtl/prf_pkg.sv
package prf_pkg;

   // Route decision of the generic release port
   typedef enum logic [1:0] {
      POOL_NONE = 2'd0,
      POOL_INT  = 2'd1,
      POOL_FP   = 2'd2
   } pool_sel_e;

   // Advance a ring pointer by a small step (0..2) inside a ring of any size
   function automatic int unsigned ring_step(int unsigned ptr, int unsigned k,
                                             int unsigned size);
      int unsigned s;
      s = ptr + k;
      if (s >= size) s = s - size;
      if (s >= size) s = s - size;
      return s;
   endfunction

endpackage

// File: rtl/prf_release_router.sv
module prf_release_router #(
   parameter int NI       = 16,
   parameter int NF       = 12,
   parameter int ZERO_REG = 0,
   parameter int IDX_W    = 5,
   localparam int TOT     = NI + NF,
   localparam int MAP_W   = 1 << IDX_W
) (
   input  logic                  gen_v,
   input  logic [IDX_W-1:0]      gen_idx,
   input  logic [1:0]            ded_v,
   input  logic [1:0][IDX_W-1:0] ded_idx,
   input  logic [TOT-1:0]        free_map,
   output logic [1:0]            push_a_v,
   output logic [1:0][IDX_W-1:0] push_a_idx,
   output logic [1:0]            push_b_v,
   output logic [1:0][IDX_W-1:0] push_b_idx,
   output logic                  rel_err
);
   import prf_pkg::*;

   logic [MAP_W-1:0] map_pad;
   pool_sel_e        gen_pool;
   logic [1:0]       err_p;

   assign map_pad = MAP_W'(free_map);

   always_comb begin
      if (int'(gen_idx) < NI)       gen_pool = POOL_INT;
      else if (int'(gen_idx) < TOT) gen_pool = POOL_FP;
      else                          gen_pool = POOL_NONE;
   end

   for (genvar p = 0; p < 2; p++) begin : g_pool
      localparam int        LO = (p == 0) ? 0 : NI;
      localparam int        HI = (p == 0) ? NI : TOT;
      localparam int        ZP = LO + ZERO_REG;
      localparam pool_sel_e MY = (p == 0) ? POOL_INT : POOL_FP;

      logic ded_in, ded_was_free, gen_hit, gen_was_free;

      assign ded_in       = (int'(ded_idx[p]) >= LO) && (int'(ded_idx[p]) < HI);
      assign ded_was_free = map_pad[ded_idx[p]];
      assign push_a_v[p]  = ded_v[p] & ded_in & ~ded_was_free;
      assign push_a_idx[p] = ded_idx[p];

      assign gen_hit      = gen_v && (gen_pool == MY) && (int'(gen_idx) != ZP);
      assign gen_was_free = map_pad[gen_idx] |
                            (push_a_v[p] & (gen_idx == ded_idx[p]));
      assign push_b_v[p]  = gen_hit & ~gen_was_free;
      assign push_b_idx[p] = gen_idx;

      assign err_p[p] = (ded_v[p] & ~ded_in) |
                        (ded_v[p] & ded_in & ded_was_free) |
                        (gen_hit & gen_was_free);
   end

   assign rel_err = |err_p;

endmodule

// File: rtl/prf_occupancy.sv
module prf_occupancy #(
   parameter int NI      = 16,
   parameter int NF      = 12,
   parameter int RSV_INT = 8,
   parameter int RSV_FP  = 8,
   parameter int IDX_W   = 5,
   localparam int TOT    = NI + NF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            set_v,
   input  logic [3:0][IDX_W-1:0] set_idx,
   input  logic [1:0]            clr_v,
   input  logic [1:0][IDX_W-1:0] clr_idx,
   output logic [TOT-1:0]        free_map
);

   for (genvar i = 0; i < TOT; i++) begin : g_bit
      localparam bit INIT = ((i >= RSV_INT) && (i < NI)) || (i >= NI + RSV_FP);
      logic set_hit, clr_hit;

      always_comb begin
         set_hit = 1'b0;
         clr_hit = 1'b0;
         for (int k = 0; k < 4; k++)
            set_hit = set_hit | (set_v[k] && (int'(set_idx[k]) == i));
         for (int k = 0; k < 2; k++)
            clr_hit = clr_hit | (clr_v[k] && (int'(clr_idx[k]) == i));
      end

      always_ff @(posedge clk) begin
         if (!rst_n) free_map[i] <= INIT;
         else        free_map[i] <= (free_map[i] | set_hit) & ~clr_hit;
      end
   end

endmodule

// File: rtl/prf_fifo_pool.sv
module prf_fifo_pool #(
   parameter int BASE  = 0,
   parameter int SIZE  = 16,
   parameter int RSV   = 8,
   parameter int IDX_W = 5,
   parameter int CNT_W = 5,
   localparam int PTR_W    = (SIZE > 1) ? $clog2(SIZE) : 1,
   localparam int INIT_CNT = SIZE - RSV
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop_req,
   input  logic             push_a_v,
   input  logic [IDX_W-1:0] push_a_idx,
   input  logic             push_b_v,
   input  logic [IDX_W-1:0] push_b_idx,
   output logic             pop_fire,
   output logic             empty_err,
   output logic [IDX_W-1:0] head_idx,
   output logic             alloc_valid,
   output logic [IDX_W-1:0] alloc_idx,
   output logic [CNT_W-1:0] free_cnt
);
   import prf_pkg::*;

   logic [IDX_W-1:0] slot_q [SIZE];
   logic [PTR_W-1:0] rd_q, wr_q, wr_nxt1, b_ptr;
   logic [1:0]       n_push;

   assign pop_fire  = pop_req & (free_cnt != '0);
   assign empty_err = pop_req & (free_cnt == '0);
   assign head_idx  = slot_q[rd_q];
   assign n_push    = {1'b0, push_a_v} + {1'b0, push_b_v};
   assign wr_nxt1   = PTR_W'(ring_step(int'(wr_q), 1, SIZE));
   assign b_ptr     = push_a_v ? wr_nxt1 : wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q        <= '0;
         wr_q        <= PTR_W'(INIT_CNT);
         free_cnt    <= CNT_W'(INIT_CNT);
         alloc_valid <= 1'b0;
         alloc_idx   <= '0;
         for (int k = 0; k < SIZE; k++)
            slot_q[k] <= (k < INIT_CNT) ? IDX_W'(BASE + RSV + k) : '0;
      end else begin
         if (push_a_v) slot_q[wr_q]  <= push_a_idx;
         if (push_b_v) slot_q[b_ptr] <= push_b_idx;
         wr_q <= PTR_W'(ring_step(int'(wr_q), int'(n_push), SIZE));
         if (pop_fire) rd_q <= PTR_W'(ring_step(int'(rd_q), 1, SIZE));
         free_cnt    <= free_cnt + CNT_W'(n_push) - CNT_W'(pop_fire);
         alloc_valid <= pop_fire;
         alloc_idx   <= pop_fire ? slot_q[rd_q] : '0;
      end
   end

endmodule

// File: rtl/prf_free_list.sv
module prf_free_list #(
   parameter int NUM_LOG_INT  = 8,
   parameter int NUM_PHYS_INT = 16,
   parameter int NUM_LOG_FP   = 8,
   parameter int NUM_PHYS_FP  = 12,
   parameter int ZERO_REG     = 0,
   localparam int TOT   = NUM_PHYS_INT + NUM_PHYS_FP,
   localparam int IDX_W = $clog2(TOT),
   localparam int MAXP  = (NUM_PHYS_INT > NUM_PHYS_FP) ? NUM_PHYS_INT : NUM_PHYS_FP,
   localparam int CNT_W = $clog2(MAXP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_alloc_req,
   input  logic             fp_alloc_req,
   output logic             int_alloc_valid,
   output logic [IDX_W-1:0] int_alloc_idx,
   output logic             fp_alloc_valid,
   output logic [IDX_W-1:0] fp_alloc_idx,
   input  logic             gen_rel_vld,
   input  logic [IDX_W-1:0] gen_rel_idx,
   input  logic             int_rel_vld,
   input  logic [IDX_W-1:0] int_rel_idx,
   input  logic             fp_rel_vld,
   input  logic [IDX_W-1:0] fp_rel_idx,
   output logic             int_nonempty,
   output logic [CNT_W-1:0] int_free_cnt,
   output logic             fp_nonempty,
   output logic [CNT_W-1:0] fp_free_cnt,
   output logic             pool_err
);

   if (NUM_LOG_INT >= NUM_PHYS_INT || NUM_LOG_FP >= NUM_PHYS_FP) begin : g_bad_size
      $error("each pool needs more physical than architectural registers");
   end
   if (ZERO_REG >= NUM_LOG_INT || ZERO_REG >= NUM_LOG_FP) begin : g_bad_zero
      $error("zero register must lie in the mapped range of both halves");
   end
   if (NUM_PHYS_INT < 2 || NUM_PHYS_FP < 2) begin : g_bad_min
      $error("each pool needs at least two registers");
   end

   logic [1:0]            pop_req, ded_v;
   logic [1:0][IDX_W-1:0] ded_idx;
   logic [1:0]            push_a_v, push_b_v, pop_fire, empty_err, a_valid;
   logic [1:0][IDX_W-1:0] push_a_idx, push_b_idx, head_idx, a_idx;
   logic [1:0][CNT_W-1:0] cnt;
   logic [TOT-1:0]        free_map;
   logic                  rel_err;
   logic [3:0]            set_v;
   logic [3:0][IDX_W-1:0] set_idx;

   assign pop_req    = {fp_alloc_req, int_alloc_req};
   assign ded_v      = {fp_rel_vld, int_rel_vld};
   assign ded_idx[0] = int_rel_idx;
   assign ded_idx[1] = fp_rel_idx;

   prf_release_router #(
      .NI(NUM_PHYS_INT), .NF(NUM_PHYS_FP), .ZERO_REG(ZERO_REG), .IDX_W(IDX_W)
   ) u_router (
      .gen_v     (gen_rel_vld),
      .gen_idx   (gen_rel_idx),
      .ded_v     (ded_v),
      .ded_idx   (ded_idx),
      .free_map  (free_map),
      .push_a_v  (push_a_v),
      .push_a_idx(push_a_idx),
      .push_b_v  (push_b_v),
      .push_b_idx(push_b_idx),
      .rel_err   (rel_err)
   );

   for (genvar p = 0; p < 2; p++) begin : g_pool
      prf_fifo_pool #(
         .BASE (p == 0 ? 0 : NUM_PHYS_INT),
         .SIZE (p == 0 ? NUM_PHYS_INT : NUM_PHYS_FP),
         .RSV  (p == 0 ? NUM_LOG_INT : NUM_LOG_FP),
         .IDX_W(IDX_W),
         .CNT_W(CNT_W)
      ) u_fifo (
         .clk        (clk),
         .rst_n      (rst_n),
         .pop_req    (pop_req[p]),
         .push_a_v   (push_a_v[p]),
         .push_a_idx (push_a_idx[p]),
         .push_b_v   (push_b_v[p]),
         .push_b_idx (push_b_idx[p]),
         .pop_fire   (pop_fire[p]),
         .empty_err  (empty_err[p]),
         .head_idx   (head_idx[p]),
         .alloc_valid(a_valid[p]),
         .alloc_idx  (a_idx[p]),
         .free_cnt   (cnt[p])
      );
   end

   assign set_v      = {push_b_v, push_a_v};
   assign set_idx[0] = push_a_idx[0];
   assign set_idx[1] = push_a_idx[1];
   assign set_idx[2] = push_b_idx[0];
   assign set_idx[3] = push_b_idx[1];

   prf_occupancy #(
      .NI(NUM_PHYS_INT), .NF(NUM_PHYS_FP),
      .RSV_INT(NUM_LOG_INT), .RSV_FP(NUM_LOG_FP), .IDX_W(IDX_W)
   ) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_v   (set_v),
      .set_idx (set_idx),
      .clr_v   (pop_fire),
      .clr_idx (head_idx),
      .free_map(free_map)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pool_err <= 1'b0;
      else        pool_err <= pool_err | rel_err | (|empty_err);
   end

   assign int_alloc_valid = a_valid[0];
   assign int_alloc_idx   = a_idx[0];
   assign fp_alloc_valid  = a_valid[1];
   assign fp_alloc_idx    = a_idx[1];
   assign int_free_cnt    = cnt[0];
   assign fp_free_cnt     = cnt[1];
   assign int_nonempty    = |cnt[0];
   assign fp_nonempty     = |cnt[1];

endmodule

// File: rtl/prf_free_list_chk.sv
module prf_free_list_chk #(
   parameter int NUM_LOG_INT  = 8,
   parameter int NUM_PHYS_INT = 16,
   parameter int NUM_LOG_FP   = 8,
   parameter int NUM_PHYS_FP  = 12,
   parameter int ZERO_REG     = 0,
   localparam int TOT   = NUM_PHYS_INT + NUM_PHYS_FP,
   localparam int IDX_W = $clog2(TOT),
   localparam int MAXP  = (NUM_PHYS_INT > NUM_PHYS_FP) ? NUM_PHYS_INT : NUM_PHYS_FP,
   localparam int CNT_W = $clog2(MAXP + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             int_alloc_req,
   input logic             fp_alloc_req,
   input logic             int_alloc_valid,
   input logic [IDX_W-1:0] int_alloc_idx,
   input logic             fp_alloc_valid,
   input logic [IDX_W-1:0] fp_alloc_idx,
   input logic             gen_rel_vld,
   input logic [IDX_W-1:0] gen_rel_idx,
   input logic             int_rel_vld,
   input logic             fp_rel_vld,
   input logic             int_nonempty,
   input logic [CNT_W-1:0] int_free_cnt,
   input logic             fp_nonempty,
   input logic [CNT_W-1:0] fp_free_cnt,
   input logic             pool_err
);

   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pool_err |=> pool_err);

   // R3
   int_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_alloc_req && int_nonempty) |=> int_alloc_valid);

   // R3
   fp_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_alloc_req && fp_nonempty) |=> fp_alloc_valid);

   // R4
   int_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_alloc_req && !int_nonempty) |=> (!int_alloc_valid && int_alloc_idx == '0 && pool_err));

   // R4
   fp_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fp_alloc_req && !fp_nonempty) |=> (!fp_alloc_valid && fp_alloc_idx == '0 && pool_err));

   // R2
   int_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_alloc_valid |-> (int'(int_alloc_idx) < NUM_PHYS_INT));

   // R2
   fp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fp_alloc_valid |-> (int'(fp_alloc_idx) >= NUM_PHYS_INT && int'(fp_alloc_idx) < TOT));

   // R13
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(int_free_cnt) <= NUM_PHYS_INT) && (int'(fp_free_cnt) <= NUM_PHYS_FP));

   // R3
   int_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_alloc_req && int_nonempty && !gen_rel_vld && !int_rel_vld)
      |=> (int_free_cnt == $past(int_free_cnt) - 1'b1));

   // R5
   discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_rel_vld && int'(gen_rel_idx) >= TOT && !int_rel_vld && !fp_rel_vld &&
       !int_alloc_req && !fp_alloc_req)
      |=> ($stable(int_free_cnt) && $stable(fp_free_cnt) && $stable(pool_err)));

endmodule

bind prf_free_list prf_free_list_chk #(
   .NUM_LOG_INT(NUM_LOG_INT), .NUM_PHYS_INT(NUM_PHYS_INT),
   .NUM_LOG_FP(NUM_LOG_FP), .NUM_PHYS_FP(NUM_PHYS_FP), .ZERO_REG(ZERO_REG)
) u_chk (.*);

// File: tb/prf_free_list_test.sv
`timescale 1ns/1ps
module prf_free_list_test;
   localparam int LI = 8, NI = 16, LF = 8, NF = 12, ZR = 0;
   localparam int TOT = NI + NF;
   localparam int IW = $clog2(TOT);
   localparam int CW = $clog2(((NI > NF) ? NI : NF) + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic int_alloc_req = 0, fp_alloc_req = 0;
   logic gen_rel_vld = 0, int_rel_vld = 0, fp_rel_vld = 0;
   logic [IW-1:0] gen_rel_idx = '0, int_rel_idx = '0, fp_rel_idx = '0;
   logic int_alloc_valid, fp_alloc_valid, int_nonempty, fp_nonempty, pool_err;
   logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
   logic [CW-1:0] int_free_cnt, fp_free_cnt;

   always #2 clk = ~clk;

   prf_free_list #(.NUM_LOG_INT(LI), .NUM_PHYS_INT(NI), .NUM_LOG_FP(LF),
                   .NUM_PHYS_FP(NF), .ZERO_REG(ZR)) uut (.*);

   int total = 0, bad = 0;
   bit done = 0;

   // reference model
   int  mq_int[$], mq_fp[$];
   bit  mfree[TOT];
   bit  merr;
   int  e_iv, e_ii, e_fv, e_fi;

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(tag, "int_valid", int'(int_alloc_valid), e_iv);
      chk(tag, "int_idx",   int'(int_alloc_idx),   e_ii);
      chk(tag, "fp_valid",  int'(fp_alloc_valid),  e_fv);
      chk(tag, "fp_idx",    int'(fp_alloc_idx),    e_fi);
      chk(tag, "int_cnt",   int'(int_free_cnt),    mq_int.size());
      chk(tag, "fp_cnt",    int'(fp_free_cnt),     mq_fp.size());
      chk(tag, "int_ne",    int'(int_nonempty),    int'(mq_int.size() != 0));
      chk(tag, "fp_ne",     int'(fp_nonempty),     int'(mq_fp.size() != 0));
      chk(tag, "err",       int'(pool_err),        int'(merr));
   endtask

   function automatic void model_reset();
      mq_int.delete(); mq_fp.delete();
      for (int k = 0; k < TOT; k++) mfree[k] = 0;
      for (int k = LI; k < NI; k++) begin mq_int.push_back(k); mfree[k] = 1; end
      for (int k = NI + LF; k < TOT; k++) begin mq_fp.push_back(k); mfree[k] = 1; end
      merr = 0; e_iv = 0; e_ii = 0; e_fv = 0; e_fi = 0;
   endfunction

   function automatic void model_push(int idx);
      mfree[idx] = 1;
      if (idx < NI) mq_int.push_back(idx); else mq_fp.push_back(idx);
   endfunction

   function automatic int pick_used(int lo, int hi);
      int cand[$];
      for (int k = lo; k < hi; k++) if (!mfree[k]) cand.push_back(k);
      if (cand.size() == 0) return lo;
      return cand[$urandom % cand.size()];
   endfunction

   task automatic do_reset(string tag);
      rst_n = 0;
      int_alloc_req = 0; fp_alloc_req = 0;
      gen_rel_vld = 0; int_rel_vld = 0; fp_rel_vld = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
      check_all(tag);
   endtask

   task automatic step(string tag, bit ir, bit fr, bit gv, int gi,
                       bit iv, int ii, bit fv, int fi);
      int isz, fsz;
      int_alloc_req = ir; fp_alloc_req = fr;
      gen_rel_vld = gv; gen_rel_idx = IW'(gi);
      int_rel_vld = iv; int_rel_idx = IW'(ii);
      fp_rel_vld = fv;  fp_rel_idx  = IW'(fi);
      isz = mq_int.size(); fsz = mq_fp.size();
      if (iv) begin
         if (ii < NI) begin
            if (mfree[ii]) merr = 1; else model_push(ii);
         end else merr = 1;
      end
      if (fv) begin
         if (fi >= NI && fi < TOT) begin
            if (mfree[fi]) merr = 1; else model_push(fi);
         end else merr = 1;
      end
      if (gv && gi < TOT) begin
         if (gi != ((gi < NI) ? ZR : NI + ZR)) begin
            if (mfree[gi]) merr = 1; else model_push(gi);
         end
      end
      e_iv = 0; e_ii = 0; e_fv = 0; e_fi = 0;
      if (ir) begin
         if (isz > 0) begin e_iv = 1; e_ii = mq_int.pop_front(); mfree[e_ii] = 0; end
         else merr = 1;
      end
      if (fr) begin
         if (fsz > 0) begin e_fv = 1; e_fi = mq_fp.pop_front(); mfree[e_fi] = 0; end
         else merr = 1;
      end
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0005eed5));
      @(negedge clk);
      do_reset("R1");
      chk("R1", "int_cnt_lit", int'(int_free_cnt), NI - LI);
      chk("R1", "fp_cnt_lit",  int'(fp_free_cnt),  NF - LF);

      // R3 / R2: first grants come from the bottom of each reset range
      step("R3", 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R2", "first_int", int'(int_alloc_idx), LI);
      step("R2", 1, 1, 0, 0, 0, 0, 0, 0);
      chk("R2", "first_fp", int'(fp_alloc_idx), NI + LF);
      // R5: routing by range, and beyond-range discard
      step("R5", 0, 0, 1, 5, 0, 0, 0, 0);
      step("R5", 0, 0, 1, 20, 0, 0, 0, 0);
      step("R5", 0, 0, 1, 30, 0, 0, 0, 0);
      chk("R5", "fp_cnt_after_discard", int'(fp_free_cnt), NF - LF);
      // R6: zero registers filtered on the generic port
      step("R6", 0, 0, 1, ZR, 0, 0, 0, 0);
      step("R6", 0, 0, 1, NI + ZR, 0, 0, 0, 0);
      chk("R6", "err_after_zero", int'(pool_err), 0);
      // R7: dedicated ports do not filter the zero register
      step("R7", 0, 0, 0, 0, 1, ZR, 0, 0);
      step("R7", 0, 0, 0, 0, 0, 0, 1, NI + ZR);
      // R10: allocate and release on the same pool in one cycle
      step("R10", 1, 0, 1, 3, 0, 0, 0, 0);
      // R11: dedicated and generic into one pool in one cycle
      step("R11", 0, 0, 1, 2, 1, 1, 0, 0);
      step("R11", 0, 1, 1, 21, 0, 0, 1, 22);
      // drain both pools to verify order (R2) and counts (R13)
      for (int k = 0; k < 16; k++) step("R2", 1, 1, 0, 0, 0, 0, 0, 0);
      chk("R13", "int_empty", int'(int_nonempty), 0);

      // R9: release of an already-free register
      do_reset("R1");
      step("R9", 0, 0, 0, 0, 1, LI + 1, 0, 0);
      chk("R9", "cnt_kept", int'(int_free_cnt), NI - LI);
      do_reset("R1");
      step("R9", 0, 0, 1, 4, 1, 4, 0, 0);
      // R8: dedicated index outside its half
      do_reset("R1");
      step("R8", 0, 0, 0, 0, 1, 20, 0, 0);
      chk("R8", "err_set", int'(pool_err), 1);
      do_reset("R1");
      step("R8", 0, 0, 0, 0, 0, 0, 1, 3);
      // R4: request to an empty pool
      do_reset("R1");
      for (int k = 0; k < NF - LF; k++) step("R4", 0, 1, 0, 0, 0, 0, 0, 0);
      step("R4", 0, 1, 1, 17, 0, 0, 0, 0);
      chk("R4", "no_valid", int'(fp_alloc_valid), 0);
      // R12: flag stays set
      for (int k = 0; k < 3; k++) idle("R12");

      // constrained random traffic
      do_reset("R1");
      for (int n = 0; n < 400; n++) begin
         bit ir, fr, gv, iv, fv;
         int gi, ii, fi;
         ir = ($urandom % 3) == 0;
         fr = ($urandom % 3) == 0;
         gv = ($urandom % 3) == 0;
         iv = ($urandom % 4) == 0;
         fv = ($urandom % 4) == 0;
         gi = (($urandom % 10) < 8) ? pick_used(0, TOT) : int'($urandom % 32);
         ii = (($urandom % 10) < 9) ? pick_used(0, NI) : int'($urandom % 32);
         fi = (($urandom % 10) < 9) ? pick_used(NI, TOT) : int'($urandom % 32);
         step("R13", ir, fr, gv, gi, iv, ii, fv, fi);
         if (n == 200) do_reset("R1");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule